// File: doc/BRIEF.md
# Synchronous Per-Output Differential Clock Gate

This block gates a bank of differential clock outputs that all derive from one reference clock. Each output pair carries a true leg that follows the clock and a complement leg that follows its inverse. An output runs only while three conditions hold together: its active-low enable pin is asserted, its software enable bit is set, and the global power-down input is inactive. When any of the three conditions fails, the output stops and parks with both legs low. Neither leg is ever tristated.

The enable pins and the power-down input are asynchronous to the clock. Each one passes through a multi-flop synchroniser and then a fixed delay pipeline, so every start and every stop lands a known number of cycles after the request. The software enable bits live in a small register that the clock domain writes directly. They are delayed by the same amount as the synchronised pins, so all three sources share one latency. The true leg's gate changes only while the clock is low. The complement leg's gate changes only while the clock is high. As a result, neither leg ever emits a shortened pulse.

Top module: `diff_clk_gate`

## Requirements
- R1: While `rstN` is low, every `difP` and `difN` bit is 0. Reset loads all software enable bits with 1, so with all pins at 0 and `pwrDown` at 0, every output runs after reset is released.
- R2: When pin `oeN[i]` is 0, enable bit i is 1 and `pwrDown` is 0, `difP[i]` equals `clkIn` and `difN[i]` equals the inverse of `clkIn`.
- R3: When pin `oeN[i]` is 1, output i is parked: `difP[i]` and `difN[i]` are both 0.
- R4: A high pulse on `regWrEn` at a rising clock edge loads `regWrData` into the software enable bits (bit i controls output i). A bit of 0 parks its output even while the pin is 0. A bit of 1 never enables an output whose pin is 1.
- R5: While `pwrDown` is 1, every output is parked, whatever the pins and enable bits hold.
- R6: With default parameters, a change in a pin, an enable bit or `pwrDown` that is applied while the clock is low takes effect in the high phase that follows the 7th rising edge after the change. This latency lies inside the allowed window of 4 to 12 cycles.
- R7: A true leg is high only during a clock-high phase, and a complement leg is high only during a clock-low phase. A starting or stopping leg emits only full-length pulses.
- R8: Changing the controls of one output has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Reference clock that is being gated |
| rstN | input | 1 | Asynchronous reset, active low |
| oeN | input | 6 | Per-output enable pins, active low (0 = run, 1 = stop), asynchronous |
| pwrDown | input | 1 | Global power-down, active high, asynchronous |
| regWrEn | input | 1 | Write strobe for the software enable bits |
| regWrData | input | 6 | New software enable bits, one per output |
| difP | output | 6 | True legs of the differential outputs |
| difN | output | 6 | Complement legs of the differential outputs |

## Verification
The bench drives several input patterns:
- Single-pin stops and starts. These measure the edge-to-edge latency and show that the other outputs keep running.
- A cleared enable bit combined with pin toggling. This tells the AND of pin and register apart from a plain override.
- Power-down with the pins wiggling underneath it. This separates the global stop from the per-output paths.
- Alternating pin masks and a pin pulse shorter than the latency. These show that every request is delayed by the same fixed amount and is neither merged nor dropped.

Every half cycle, a scoreboard compares both legs of all outputs against the delayed expectation. This comparison catches any pulse in the wrong phase, which is how a runt pulse or a wrong latency would appear.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  parameter int unsigned GATE_COUNT = 6;

  // strobes passed from control to datapath, already aligned to the clock
  typedef struct packed {
    logic [GATE_COUNT-1:0] runReq;
  } gate_strobe_t;
endpackage

// File: rtl/dcg_sync.sv
module dcg_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [DEPTH-1:0][WIDTH-1:0] stages;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stages <= {DEPTH{RESET_VAL}};
    end else begin
      stages[0] <= din;
      for (int s = 1; s < DEPTH; s++) begin
        stages[s] <= stages[s-1];
      end
    end
  end

  assign dout = stages[DEPTH-1];
endmodule

// File: rtl/dcg_ctrl.sv
module dcg_ctrl
  import dcg_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned PIPE_DEPTH = 4
) (
  input  logic                  clkIn,
  input  logic                  rstN,
  input  logic [GATE_COUNT-1:0] oeN,
  input  logic                  pwrDown,
  input  logic                  regWrEn,
  input  logic [GATE_COUNT-1:0] regWrData,
  output logic [GATE_COUNT-1:0] swReg,
  output gate_strobe_t          strobes
);
  localparam int unsigned ALIGN_DEPTH = SYNC_DEPTH - 1;

  logic [GATE_COUNT-1:0] pinOnSync;
  logic                  pdSync;
  logic [GATE_COUNT-1:0] swAligned;
  logic [GATE_COUNT-1:0] wantRun;
  logic [GATE_COUNT-1:0] runDelayed;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)        swReg <= '1;
    else if (regWrEn) swReg <= regWrData;
  end

  dcg_sync #(.WIDTH(GATE_COUNT), .DEPTH(SYNC_DEPTH), .RESET_VAL('0)) uPinSync (
    .clk(clkIn), .rstN(rstN), .din(~oeN), .dout(pinOnSync));

  // power-down resets to asserted so outputs stay parked until it is sampled
  dcg_sync #(.WIDTH(1), .DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) uPdSync (
    .clk(clkIn), .rstN(rstN), .din(pwrDown), .dout(pdSync));

  // register bits are already in this domain; delay them to match the pin path
  dcg_sync #(.WIDTH(GATE_COUNT), .DEPTH(ALIGN_DEPTH), .RESET_VAL('0)) uSwAlign (
    .clk(clkIn), .rstN(rstN), .din(swReg), .dout(swAligned));

  assign wantRun = pinOnSync & swAligned & {GATE_COUNT{~pdSync}};

  dcg_sync #(.WIDTH(GATE_COUNT), .DEPTH(PIPE_DEPTH), .RESET_VAL('0)) uLatPipe (
    .clk(clkIn), .rstN(rstN), .din(wantRun), .dout(runDelayed));

  assign strobes.runReq = runDelayed;
endmodule

// File: rtl/dcg_datapath.sv
module dcg_datapath
  import dcg_pkg::*;
(
  input  logic                  clkIn,
  input  logic                  rstN,
  input  gate_strobe_t          strobes,
  output logic [GATE_COUNT-1:0] difP,
  output logic [GATE_COUNT-1:0] difN
);
  for (genvar g = 0; g < GATE_COUNT; g++) begin : gLane
    logic trueGate;
    logic compGate;

    // true-leg gate moves only while the clock is low
    always_ff @(negedge clkIn or negedge rstN) begin
      if (!rstN) trueGate <= 1'b0;
      else       trueGate <= strobes.runReq[g];
    end

    // complement-leg gate follows half a cycle later, while the clock is high
    always_ff @(posedge clkIn or negedge rstN) begin
      if (!rstN) compGate <= 1'b0;
      else       compGate <= trueGate;
    end

    assign difP[g] = clkIn & trueGate;
    assign difN[g] = ~clkIn & compGate;
  end
endmodule

// File: rtl/diff_clk_gate.sv
module diff_clk_gate
  import dcg_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned PIPE_DEPTH = 4
) (
  input  logic                  clkIn,
  input  logic                  rstN,
  input  logic [GATE_COUNT-1:0] oeN,
  input  logic                  pwrDown,
  input  logic                  regWrEn,
  input  logic [GATE_COUNT-1:0] regWrData,
  output logic [GATE_COUNT-1:0] difP,
  output logic [GATE_COUNT-1:0] difN
);
  gate_strobe_t          strobes;
  logic [GATE_COUNT-1:0] swReg;

  dcg_ctrl #(.SYNC_DEPTH(SYNC_DEPTH), .PIPE_DEPTH(PIPE_DEPTH)) uCtrl (
    .clkIn(clkIn), .rstN(rstN), .oeN(oeN), .pwrDown(pwrDown),
    .regWrEn(regWrEn), .regWrData(regWrData), .swReg(swReg), .strobes(strobes));

  dcg_datapath uPath (
    .clkIn(clkIn), .rstN(rstN), .strobes(strobes), .difP(difP), .difN(difN));
endmodule

// File: rtl/dcg_checker.sv
module dcg_checker
  import dcg_pkg::*;
(
  input logic                  clkIn,
  input logic                  rstN,
  input logic [GATE_COUNT-1:0] oeN,
  input logic                  pwrDown,
  input logic [GATE_COUNT-1:0] swReg,
  input logic [GATE_COUNT-1:0] difP,
  input logic [GATE_COUNT-1:0] difN
);
  logic [GATE_COUNT-1:0] cond;
  logic [GATE_COUNT-1:0] prevCond;
  logic [3:0]            steadyCnt;
  logic [3:0]            pdCnt;

  assign cond = ~oeN & swReg & {GATE_COUNT{~pwrDown}};

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      prevCond  <= '0;
      steadyCnt <= '0;
      pdCnt     <= '0;
    end else begin
      prevCond <= cond;
      if (cond != prevCond)   steadyCnt <= '0;
      else if (steadyCnt != 4'hF) steadyCnt <= steadyCnt + 4'd1;
      if (!pwrDown)           pdCnt <= '0;
      else if (pdCnt != 4'hF) pdCnt <= pdCnt + 4'd1;
    end
  end

  // R1: parked while in reset
  p_reset_park_r1: assert property (@(negedge clkIn) !rstN |-> (difP == '0));

  // R7: true leg never high in a low phase, complement never high in a high phase
  p_true_phase_r7: assert property (@(posedge clkIn) disable iff (!rstN) difP == '0);
  p_comp_phase_r7: assert property (@(negedge clkIn) disable iff (!rstN) difN == '0);

  // R2: after long steady controls, outputs follow the combined enable
  p_steady_true_r2: assert property (@(negedge clkIn) disable iff (!rstN)
    (steadyCnt >= 4'd8) |-> (difP == prevCond));
  p_steady_comp_r2: assert property (@(posedge clkIn) disable iff (!rstN)
    (steadyCnt >= 4'd8) |-> (difN == prevCond));

  // R5: a held power-down parks every output
  p_pwrdown_park_r5: assert property (@(negedge clkIn) disable iff (!rstN)
    (pdCnt >= 4'd8) |-> (difP == '0));
endmodule

bind diff_clk_gate dcg_checker uChk (
  .clkIn(clkIn), .rstN(rstN), .oeN(oeN), .pwrDown(pwrDown),
  .swReg(swReg), .difP(difP), .difN(difN));

// File: tb/diff_clk_gate_test.sv
`timescale 1ns/1ps
module diff_clk_gate_test;
  localparam int N = 6;
  localparam int LAT = 7;

  logic clkIn = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] oeN = '0;
  logic pwrDown = 1'b0;
  logic regWrEn = 1'b0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] difP, difN;

  diff_clk_gate uut (.clkIn(clkIn), .rstN(rstN), .oeN(oeN), .pwrDown(pwrDown),
    .regWrEn(regWrEn), .regWrData(regWrData), .difP(difP), .difN(difN));

  always #2.5 clkIn = ~clkIn;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  string curTag = "R2";

  logic [N-1:0] mOeN = '0;
  logic [N-1:0] mReg = '1;
  logic         mPd  = 1'b0;
  logic [N-1:0] expVec = '0;

  typedef struct { int due; logic [N-1:0] val; } exp_item_t;
  exp_item_t expQ[$];

  always @(posedge clkIn) cyc++;

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] modelRun();
    return ~mOeN & mReg & {N{~mPd}};
  endfunction

  // driver: applies new controls while the clock is low and queues the delayed expectation
  task automatic pushExp();
    exp_item_t it;
    it.due = cyc + LAT;
    it.val = modelRun();
    expQ.push_back(it);
  endtask

  task automatic setPins(input logic [N-1:0] v, input string tag);
    @(negedge clkIn); #0.5;
    oeN = v; mOeN = v; curTag = tag;
    pushExp();
  endtask

  task automatic setPd(input logic v, input string tag);
    @(negedge clkIn); #0.5;
    pwrDown = v; mPd = v; curTag = tag;
    pushExp();
  endtask

  task automatic writeReg(input logic [N-1:0] v, input string tag);
    @(negedge clkIn); #0.5;
    regWrEn = 1'b1; regWrData = v; mReg = v; curTag = tag;
    pushExp();
    @(posedge clkIn); #0.5;
    regWrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clkIn);
  endtask

  // monitor: pops due expectations and compares both legs every half cycle
  initial begin
    forever begin
      @(posedge clkIn); #1;
      while (expQ.size() > 0 && expQ[0].due <= cyc) expVec = expQ.pop_front().val;
      if (monOn) begin
        check(difP == expVec, {curTag, " R8 true leg high phase"}, difP, expVec);
        check(difN == '0, "R7 complement low in high phase", difN, '0);
      end
      @(negedge clkIn); #1;
      if (monOn) begin
        check(difP == '0, "R7 true low in low phase", difP, '0);
        check(difN == expVec, {curTag, " R8 complement leg low phase"}, difN, expVec);
      end
    end
  end

  // R6: measure rising edges until output idx reaches the new state
  task automatic measurePin(input int idx, input logic turnOn, input string tag);
    logic [N-1:0] v;
    int k;
    v = mOeN;
    v[idx] = ~turnOn;
    setPins(v, tag);
    k = 0;
    for (int s = 1; s <= 20; s++) begin
      @(posedge clkIn); #1.2;
      if (difP[idx] == turnOn) begin k = s; break; end
    end
    check(k >= 4 && k <= 12, "R6 latency window 4..12", N'(k), N'(LAT));
    check(k == LAT, "R6 fixed latency", N'(k), N'(LAT));
  endtask

  task automatic measureReg(input int idx, input string tag);
    logic [N-1:0] v;
    int k;
    v = mReg;
    v[idx] = 1'b1;
    @(negedge clkIn); #0.5;
    regWrEn = 1'b1; regWrData = v; mReg = v; curTag = tag;
    pushExp();
    k = 0;
    for (int s = 1; s <= 20; s++) begin
      @(posedge clkIn); #1.2;
      regWrEn = 1'b0;
      if (difP[idx] == 1'b1) begin k = s; break; end
    end
    check(k == LAT, "R6 register path latency", N'(k), N'(LAT));
  endtask

  initial begin
    // R1: reset state in both phases
    repeat (3) begin
      @(posedge clkIn); #1;
      check(difP == '0 && difN == '0, "R1 parked in reset high phase", difP | difN, '0);
      @(negedge clkIn); #1;
      check(difP == '0 && difN == '0, "R1 parked in reset low phase", difP | difN, '0);
    end
    @(negedge clkIn); #0.5;
    rstN = 1'b1;
    curTag = "R1";
    pushExp();
    monOn = 1'b1;
    waitCycles(12);
    check(expVec == '1, "R1 register resets to ones", expVec, '1);

    // R3 and R6: stop and restart one pin, others keep running
    measurePin(2, 1'b0, "R3");
    waitCycles(4);
    measurePin(2, 1'b1, "R2");
    waitCycles(4);
    measurePin(5, 1'b0, "R3");
    measurePin(5, 1'b1, "R2");

    // R4: cleared enable bits override enabled pins; pin toggles cannot revive
    writeReg(6'b101101, "R4");
    waitCycles(10);
    setPins(6'b000010, "R4");
    waitCycles(4);
    setPins(6'b000000, "R4");
    waitCycles(10);
    setPins(6'b000100, "R4");
    waitCycles(10);
    setPins(6'b000000, "R4");
    measureReg(4, "R4");
    measureReg(1, "R4");
    waitCycles(8);

    // R5: power-down parks everything while pins and register move
    setPd(1'b1, "R5");
    waitCycles(9);
    setPins(6'b010101, "R5");
    writeReg(6'b110011, "R5");
    waitCycles(9);
    setPd(1'b0, "R5");
    waitCycles(10);
    writeReg(6'b111111, "R5");
    waitCycles(10);

    // R8: alternating masks and a pulse shorter than the latency
    setPins(6'b101010, "R8");
    waitCycles(10);
    setPins(6'b000000, "R8");
    setPins(6'b000000, "R8");
    setPins(6'b001000, "R8");
    setPins(6'b000000, "R8");
    waitCycles(12);
    setPins(6'b111111, "R3");
    waitCycles(10);
    setPins(6'b000000, "R2");
    waitCycles(12);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule